// File: doc/BRIEF.md
# Parity-Predicted Adder with Concurrent Check

This block adds two W-bit operands that each travel with an even-parity bit and a carry-in. It returns the W-bit sum with a parity bit of its own. Addition does not keep parity, so the output parity bit is never derived from the sum. It is predicted instead. The prediction takes the two incoming parity bits and the XOR of every carry that enters a sum bit. Those carries come from a second carry chain that shares no gates with the main adder's chain. A fault in the adder's carries therefore changes the sum without changing the prediction in the same way.

A checker forms the parity of the sum that was actually produced and compares it with the prediction. It also tests each operand against its own parity bit. Any mismatch raises an error flag.

Sum, predicted parity and flag are captured together on one clock edge. A valid strobe follows the input strobe by one cycle. A test input can invert one carry of the main adder so that the detection path can be exercised.

Top module: `ppa_top`

## Requirements
- R1: With fault injection off, `sum` equals (a + b + c_in) mod 2^W.
- R2: `sum_par` equals a_par XOR b_par XOR the XOR of the carries into bits 0..W-1, where the carry into bit 0 is c_in and the carry into bit i is the carry out of bit i-1. The carries are taken from the duplicate chain, so `sum_par` does not depend on `flt_en` or `flt_sel`.
- R3: For W=8, a=8'b10110001 with a_par=0, b=8'b00111011 with b_par=1 and c_in=0, the block returns sum=8'b11101100, sum_par=1 and err=0.
- R4: `err` is 1 when the XOR of a's bits differs from a_par, or when the XOR of b's bits differs from b_par. The parity convention is even: the bit makes the XOR of data and parity zero.
- R5: With flt_en=1 and flt_sel=i (where i<W), only the main adder's carry into bit i is inverted. The inverted carry propagates through the upper bits, so `sum` becomes (a+b+c_in+2^i) mod 2^W when that carry was 0, and (a+b+c_in-2^i) mod 2^W when it was 1.
- R6: `err` is 1 exactly when R4 applies or when the XOR of the bits of the returned `sum` differs from `sum_par`.
- R7: `out_valid` in a cycle equals `in_valid` of the previous cycle. `sum`, `sum_par` and `err` show the inputs sampled at the edge where `in_valid` was 1.
- R8: While `in_valid` is 0 at an edge, `sum`, `sum_par` and `err` keep their values.
- R9: A synchronous reset with rst_n=0 clears `out_valid`, `sum`, `sum_par` and `err`, whatever the value of `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| a | input | W | First operand |
| a_par | input | 1 | Even parity bit of `a` |
| b | input | W | Second operand |
| b_par | input | 1 | Even parity bit of `b` |
| c_in | input | 1 | Carry into bit 0 |
| flt_en | input | 1 | Enables inversion of one main-adder carry |
| flt_sel | input | max(1,clog2(W)) | Index of the carry to invert |
| out_valid | output | 1 | Registered outputs hold a new result |
| sum | output | W | Registered sum from the main adder |
| sum_par | output | 1 | Registered predicted parity of the sum |
| err | output | 1 | Registered parity or operand error flag |

## Verification
The bench builds two instances of the block. The first uses W=4. At that width every pair of operands is swept against both carry-in values, all four combinations of correct and wrong operand parity bits, and every fault position plus the fault-free case. That sweep covers every carry pattern and shows which injected flips change the sum parity and which cancel out. The second instance uses W=8. It reproduces the worked example exactly and takes a few thousand pseudo-random vectors with faults at all eight positions. Both instances also go through the reset and hold cases.

// File: rtl/ppa_pkg.sv
// Package: ppa_pkg
// Shared sizing helpers for the parity-predicted adder.
// Assumes widths of one or more bits.
package ppa_pkg;

    // Width of a select that can name any one of w positions.
    function automatic int sel_width(int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

    // Leaf count of a balanced binary tree holding n inputs.
    function automatic int tree_leaves(int n);
        return (n > 1) ? (1 << $clog2(n)) : 1;
    endfunction

endpackage

// File: rtl/ppa_xor_tree.sv
// Module: ppa_xor_tree
// Balanced XOR reduction of N bits. Leaves past N are padded with zero.
// Assumes N >= 1. The depth is clog2(N) gate levels.
module ppa_xor_tree #(
    parameter int N = 8
) (
    input  logic [N-1:0] bits,
    output logic         odd
);
    localparam int P = ppa_pkg::tree_leaves(N);

    logic [2*P-2:0] node;

    // Fill the leaves: real inputs first, zero padding after.
    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign node[P-1+j] = bits[j];
        end else begin : g_pad
            assign node[P-1+j] = 1'b0;
        end
    end

    // Combine child pairs toward the root.
    for (genvar k = 0; k < P-1; k++) begin : g_node
        assign node[k] = node[2*k+1] ^ node[2*k+2];
    end

    assign odd = node[0];
endmodule

// File: rtl/ppa_main_adder.sv
// Module: ppa_main_adder
// Ripple-carry adder that produces the data sum.
// A test hook inverts the carry into one selected bit. The inverted value
// feeds both that sum bit and the carry logic above it, as a real fault would.
// Assumes flt_sel values of W or more select nothing.
module ppa_main_adder #(
    parameter int W    = 8,
    parameter int SELW = ppa_pkg::sel_width(W)
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    input  logic            flt_en,
    input  logic [SELW-1:0] flt_sel,
    output logic [W-1:0]    sum
);
    logic [W-1:0] flip;
    logic [W-1:0] c;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Decode the fault position for this bit.
        assign flip[i] = flt_en && (flt_sel == SELW'(i));
        if (i == 0) begin : g_lsb
            // Carry into bit 0 is the external carry-in.
            assign c[i] = cin ^ flip[i];
        end else begin : g_up
            // Majority carry from the bit below.
            assign c[i] = ((a[i-1] & b[i-1]) | ((a[i-1] ^ b[i-1]) & c[i-1])) ^ flip[i];
        end
        // Sum bit from the operands and the incoming carry.
        assign sum[i] = a[i] ^ b[i] ^ c[i];
    end
endmodule

// File: rtl/ppa_carry_dup.sv
// Module: ppa_carry_dup
// Second carry network used only for parity prediction.
// It works from generate and propagate terms and shares no gate with the
// main adder. A fault in one chain therefore cannot reach the other.
module ppa_carry_dup #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] carries
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;

    // Per-bit generate and propagate terms.
    assign gen  = a & b;
    assign prop = a | b;

    for (genvar i = 0; i < W; i++) begin : g_c
        if (i == 0) begin : g_lsb
            // Carry into bit 0.
            assign carries[i] = cin;
        end else begin : g_up
            // Carry into bit i from bit i-1.
            assign carries[i] = gen[i-1] | (prop[i-1] & carries[i-1]);
        end
    end
endmodule

// File: rtl/ppa_top.sv
// Module: ppa_top
// Adder for parity-encoded operands with a predicted output parity and a
// concurrent check. The predictor XORs the operand parity bits with the
// duplicate carries. The checker compares that prediction with the parity
// of the real sum and also tests each operand against its parity bit.
// Results are registered together. The parity convention is even.
module ppa_top #(
    parameter int W    = 8,
    parameter int SELW = ppa_pkg::sel_width(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [W-1:0]    a,
    input  logic            a_par,
    input  logic [W-1:0]    b,
    input  logic            b_par,
    input  logic            c_in,
    input  logic            flt_en,
    input  logic [SELW-1:0] flt_sel,
    output logic            out_valid,
    output logic [W-1:0]    sum,
    output logic            sum_par,
    output logic            err
);
    logic [W-1:0] raw_sum;
    logic [W-1:0] dup_c;
    logic         pred_par;
    logic         real_par;
    logic         a_par_calc;
    logic         b_par_calc;
    logic         err_next;

    ppa_main_adder #(.W(W), .SELW(SELW)) u_add (
        .a(a), .b(b), .cin(c_in), .flt_en(flt_en), .flt_sel(flt_sel), .sum(raw_sum)
    );

    ppa_carry_dup #(.W(W)) u_dup (
        .a(a), .b(b), .cin(c_in), .carries(dup_c)
    );

    // Predicted parity over both parity bits and all duplicate carries.
    ppa_xor_tree #(.N(W+2)) u_pred (
        .bits({a_par, b_par, dup_c}), .odd(pred_par)
    );

    // Parity actually present in the produced sum.
    ppa_xor_tree #(.N(W)) u_real (
        .bits(raw_sum), .odd(real_par)
    );

    // Operand parity regeneration.
    ppa_xor_tree #(.N(W)) u_pa (.bits(a), .odd(a_par_calc));
    ppa_xor_tree #(.N(W)) u_pb (.bits(b), .odd(b_par_calc));

    // Combine the sum check with the two operand checks.
    always_comb begin
        err_next = (real_par ^ pred_par) | (a_par_calc ^ a_par) | (b_par_calc ^ b_par);
    end

    // Capture the result bundle on an accepted input. Hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum       <= '0;
            sum_par   <= 1'b0;
            err       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum     <= raw_sum;
                sum_par <= pred_par;
                err     <= err_next;
            end
        end
    end
endmodule

// File: rtl/ppa_checker.sv
// Module: ppa_checker
// Port-level properties of ppa_top. Bound to every instance below.
module ppa_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] a,
    input logic         a_par,
    input logic [W-1:0] b,
    input logic         b_par,
    input logic         flt_en,
    input logic         out_valid,
    input logic [W-1:0] sum,
    input logic         sum_par,
    input logic         err
);
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sum == '0 && !sum_par && !err));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum) && $stable(sum_par) && $stable(err)));

    a_r6_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((^sum) != sum_par)) |-> err);

    a_r6_no_false_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flt_en && ((^a) == a_par) && ((^b) == b_par)) |=> !err);

    a_r4_operand_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (((^a) != a_par) || ((^b) != b_par))) |=> err);
endmodule

bind ppa_top ppa_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .a_par(a_par),
    .b(b), .b_par(b_par), .flt_en(flt_en), .out_valid(out_valid),
    .sum(sum), .sum_par(sum_par), .err(err)
);

// File: tb/tb_ppa_top.sv
module tb_ppa_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // W=4 instance
    logic       v4 = 0, ap4 = 0, bp4 = 0, ci4 = 0, fe4 = 0;
    logic [3:0] a4 = 0, b4 = 0;
    logic [1:0] fs4 = 0;
    logic       ov4, sp4, er4;
    logic [3:0] s4;

    // W=8 instance
    logic       v8 = 0, ap8 = 0, bp8 = 0, ci8 = 0, fe8 = 0;
    logic [7:0] a8 = 0, b8 = 0;
    logic [2:0] fs8 = 0;
    logic       ov8, sp8, er8;
    logic [7:0] s8;

    ppa_top #(.W(4)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v4), .a(a4), .a_par(ap4), .b(b4),
        .b_par(bp4), .c_in(ci4), .flt_en(fe4), .flt_sel(fs4), .out_valid(ov4),
        .sum(s4), .sum_par(sp4), .err(er4)
    );

    ppa_top #(.W(8)) dut_w8 (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .a(a8), .a_par(ap8), .b(b8),
        .b_par(bp8), .c_in(ci8), .flt_en(fe8), .flt_sel(fs8), .out_valid(ov8),
        .sum(s8), .sum_par(sp8), .err(er8)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arithmetic reference: sum with optional carry flip, prediction, flag.
    function automatic void model(int w, int a, int b, int ci, int fe, int fs,
                                  int ap, int bp, output int s, output int p,
                                  output int e);
        int mask = (1 << w) - 1;
        int tot = a + b + ci;
        int lowm = (1 << fs) - 1;
        int cfs = (fs == 0) ? ci : ((((a & lowm) + (b & lowm) + ci) >> fs) & 1);
        int faulty = tot;
        int operr;
        if (fe != 0 && fs < w) faulty = (cfs != 0) ? tot - (1 << fs) : tot + (1 << fs);
        s = faulty & mask;
        p = ap ^ bp ^ ($countones(a) & 1) ^ ($countones(b) & 1) ^ ($countones(tot & mask) & 1);
        operr = ((($countones(a) & 1) != ap) || (($countones(b) & 1) != bp)) ? 1 : 0;
        e = (operr != 0 || (($countones(s) & 1) != p)) ? 1 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int es, ep, ee;
        int hs, hp, he;
        // R9: reset wins over in_valid
        v4 = 1; a4 = 4'hF; b4 = 4'h7; v8 = 1; a8 = 8'hFF; b8 = 8'h01;
        repeat (3) @(negedge clk);
        check("R9 out_valid", ov4, 0);
        check("R9 sum", s4, 0);
        check("R9 sum_par", sp4, 0);
        check("R9 err", er4, 0);
        check("R9 w8 out_valid", ov8, 0);
        check("R9 w8 sum", s8, 0);
        v4 = 0; v8 = 0;
        rst_n = 1;
        @(negedge clk);

        // R3: worked example on the 8-bit instance
        v8 = 1; a8 = 8'b10110001; ap8 = 0; b8 = 8'b00111011; bp8 = 1; ci8 = 0; fe8 = 0;
        @(negedge clk);
        check("R3 sum", s8, 8'b11101100);
        check("R3 sum_par", sp8, 1);
        check("R3 err", er8, 0);
        check("R7 out_valid", ov8, 1);
        v8 = 0;
        @(negedge clk);

        // R1 R2 R4 R5 R6 R7: exhaustive sweep of the 4-bit instance
        for (int f = 0; f < 5; f++)
            for (int pp = 0; pp < 4; pp++)
                for (int ci = 0; ci < 2; ci++)
                    for (int a = 0; a < 16; a++)
                        for (int b = 0; b < 16; b++) begin
                            v4 = 1; a4 = 4'(a); b4 = 4'(b); ci4 = 1'(ci);
                            ap4 = 1'(($countones(a) & 1) ^ (pp & 1));
                            bp4 = 1'(($countones(b) & 1) ^ (pp >> 1));
                            fe4 = (f < 4); fs4 = 2'(f & 3);
                            model(4, a, b, ci, (f < 4) ? 1 : 0, f & 3, int'(ap4), int'(bp4), es, ep, ee);
                            @(negedge clk);
                            check((f < 4) ? "R5 sum" : "R1 sum", s4, es);
                            check("R2 sum_par", sp4, ep);
                            check((pp != 0) ? "R4 err" : "R6 err", er4, ee);
                            check("R7 out_valid", ov4, 1);
                        end

        // R8: idle cycles with changing inputs keep the outputs
        hs = s4; hp = sp4; he = er4;
        for (int k = 0; k < 4; k++) begin
            v4 = 0; a4 = 4'(k * 5); b4 = 4'(k + 3); ap4 = ~ap4; fe4 = 1'(k & 1);
            @(negedge clk);
            check("R8 sum hold", s4, hs);
            check("R8 sum_par hold", sp4, hp);
            check("R8 err hold", er4, he);
            check("R7 out_valid low", ov4, 0);
        end

        // R1 R2 R5 R6: pseudo-random vectors on the 8-bit instance
        for (int n = 0; n < 3000; n++) begin
            int a = int'($urandom & 32'hFF);
            int b = int'($urandom & 32'hFF);
            int ci = int'($urandom & 1);
            int f = int'($urandom % 9);
            int bad = int'($urandom % 8);
            v8 = 1; a8 = 8'(a); b8 = 8'(b); ci8 = 1'(ci);
            ap8 = 1'(($countones(a) & 1) ^ ((bad == 0) ? 1 : 0));
            bp8 = 1'(($countones(b) & 1) ^ ((bad == 1) ? 1 : 0));
            fe8 = (f < 8); fs8 = 3'(f & 7);
            model(8, a, b, ci, (f < 8) ? 1 : 0, f & 7, int'(ap8), int'(bp8), es, ep, ee);
            @(negedge clk);
            check((f < 8) ? "R5 w8 sum" : "R1 w8 sum", s8, es);
            check("R2 w8 sum_par", sp8, ep);
            check("R6 w8 err", er8, ee);
        end
        v8 = 0;
        @(negedge clk);
        check("R7 w8 out_valid low", ov8, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule